// File: doc/BRIEF.md
# PLL Divider Reprogramming Sequencer

This block moves a clock generator from one divider set to another without glitching the clocks downstream. A single start pulse brings in the target input divider, output divider, feedback multiplier and loop bandwidth value. The block then runs the whole update on its own. If the mode mux is driving the PLL output to the clock tree, it first moves the mux to the slow reference. It then holds the PLL in reset while it rewrites the four configuration fields and releases the reset. After that it waits a settle time that grows with the input divider. Finally it polls the analog lock indication, giving up after a bounded number of samples.

If the PLL fails to lock, the sequencer replays the same reset-and-write sequence with the divider set that was active before the start and raises an error flag. A failure during that replay ends the operation with the error flag still set, and no further attempt is made. In every case the mux returns to the PLL output only if the sequencer moved it away at the start. The end of the operation is marked by a one-cycle done pulse. Between operations, software-side logic sets the mode mux through a simple write strobe.

Top module: `pll_reprog_seq`

## Requirements
- R1: On an accepted start, the configuration fields that are active at that moment are kept as the fallback set.
- R2: Mode codes are 0 = slow reference, 1 = PLL output, 2 = deep-slow. On an accepted start, a mode of 1 becomes 0 on the following cycle. Modes 0 and 2 are not changed by the sequencer.
- R3: `pllRst` rises on the edge that accepts the start. On the next edge, each configuration output takes its target value minus one. On the edge after that, `pllRst` falls. Configuration outputs never change while `pllRst` is low.
- R4: After `pllRst` falls, the block waits ((nr*500)/24 + 1) * US_CYC cycles before the first lock sample, where nr = `cfgInDivM1` + 1. Lock is ignored during this wait. With lock already high, `done` is seen exactly settle + 2 cycles after `pllRst` is seen low.
- R5: Lock is sampled once per cycle, for up to POLL_MAX samples. The first high sample ends the pass successfully.
- R6: If all POLL_MAX samples are low on the first pass, `err` is set. The reset-and-write sequence then repeats with the fallback set from R1.
- R7: `done` is high for exactly one cycle when an operation ends. `err` stays set until the next accepted start, which clears it on the following cycle.
- R8: While `busy` is high, a start request is ignored and so is a mode write. When idle, a mode write takes effect on the next cycle unless a start arrives in the same cycle, in which case the mode write is dropped.
- R9: If the fallback pass also times out, the operation ends with `err` set and the fallback fields in place. No third pass is started.
- R10: When the operation ends, the mode becomes 1 again if and only if R2 changed it from 1 to 0 at the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Start request, sampled when idle |
| tgtInDiv | input | NR_W+1 | Target input divider (actual value, 1 or more) |
| tgtOutDiv | input | NO_W+1 | Target output divider (actual value) |
| tgtMult | input | NF_W+1 | Target feedback multiplier (actual value) |
| tgtBw | input | NB_W+1 | Target bandwidth value (actual value) |
| modeWe | input | 1 | Mode write strobe |
| modeWrData | input | 2 | Mode value to write |
| lockIn | input | 1 | Lock indication from the PLL |
| modeSel | output | 2 | Mode mux select |
| pllRst | output | 1 | PLL reset |
| cfgInDivM1 | output | NR_W | Input divider field (value minus one) |
| cfgOutDivM1 | output | NO_W | Output divider field (value minus one) |
| cfgMultM1 | output | NF_W | Multiplier field (value minus one) |
| cfgBwM1 | output | NB_W | Bandwidth field (value minus one) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| err | output | 1 | Sticky lock failure flag |

## Verification
The hardest path to reach is the fallback pass that does lock. The bench holds lock low through the first poll window. It watches `err` rise at the timeout, and only then raises lock, so that the replayed pass succeeds. That run checks three things: the fields are back at their old values, `err` is still set, and a parked mux is restored. A second run keeps lock low through both passes to reach the ending that makes no third attempt. Its mux starts in deep-slow mode, which the sequencer must not touch. The settle window is timed from the `pllRst` falling edge to the `done` pulse.

// File: rtl/pll_reprog_pkg.sv
package pll_reprog_pkg;
  localparam logic [1:0] MODE_SLOW = 2'd0;
  localparam logic [1:0] MODE_PLL  = 2'd1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_RELEASE, ST_SETTLE, ST_POLL, ST_FINISH
  } seqState_t;

  typedef struct packed {
    logic capture;
    logic park;
    logic restore;
    logic clrErr;
    logic setErr;
    logic setRst;
    logic clrRst;
    logic writeCfg;
    logic useOld;
    logic loadSettle;
    logic decSettle;
    logic clrPoll;
    logic incPoll;
    logic doneSet;
    logic modeWrOk;
  } seqStrb_t;
endpackage

// File: rtl/pll_reprog_dp.sv
module pll_reprog_dp
  import pll_reprog_pkg::*;
#(
  parameter int NR_W     = 6,
  parameter int NO_W     = 4,
  parameter int NF_W     = 13,
  parameter int NB_W     = 12,
  parameter int US_CYC   = 24,
  parameter int POLL_MAX = 64
) (
  input  logic            clk,
  input  logic            rstN,
  input  seqStrb_t        strb,
  input  logic [NR_W:0]   tgtInDiv,
  input  logic [NO_W:0]   tgtOutDiv,
  input  logic [NF_W:0]   tgtMult,
  input  logic [NB_W:0]   tgtBw,
  input  logic [1:0]      modeWrData,
  output logic            settleZero,
  output logic            pollLast,
  output logic [1:0]      modeSel,
  output logic            pllRst,
  output logic [NR_W-1:0] cfgInDivM1,
  output logic [NO_W-1:0] cfgOutDivM1,
  output logic [NF_W-1:0] cfgMultM1,
  output logic [NB_W-1:0] cfgBwM1,
  output logic            done,
  output logic            err
);
  localparam int NR_MAX   = 2 ** NR_W;
  localparam int MAX_US   = (NR_MAX * 500) / 24 + 1;
  localparam int CNT_W    = $clog2(MAX_US * US_CYC + 1);
  localparam int POLL_W   = (POLL_MAX > 2) ? $clog2(POLL_MAX) : 1;

  logic [NR_W-1:0] newIn,  oldIn;
  logic [NO_W-1:0] newOut, oldOut;
  logic [NF_W-1:0] newMul, oldMul;
  logic [NB_W-1:0] newBw,  oldBw;
  logic            parked;
  logic [CNT_W-1:0]  settleCnt, settleLoad;
  logic [POLL_W-1:0] pollCnt;

  always_comb begin
    int nrVal;
    int usVal;
    nrVal      = int'(cfgInDivM1) + 1;
    usVal      = (nrVal * 500) / 24 + 1;
    settleLoad = CNT_W'(usVal * US_CYC - 1);
  end

  assign settleZero = (settleCnt == '0);
  assign pollLast   = (pollCnt == POLL_W'(POLL_MAX - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      newIn <= '0; newOut <= '0; newMul <= '0; newBw <= '0;
      oldIn <= '0; oldOut <= '0; oldMul <= '0; oldBw <= '0;
      cfgInDivM1 <= '0; cfgOutDivM1 <= '0; cfgMultM1 <= '0; cfgBwM1 <= '0;
      modeSel <= MODE_SLOW;
      parked  <= 1'b0;
      pllRst  <= 1'b0;
      err     <= 1'b0;
      done    <= 1'b0;
      settleCnt <= '0;
      pollCnt   <= '0;
    end else begin
      done <= strb.doneSet;
      if (strb.capture) begin
        oldIn  <= cfgInDivM1;
        oldOut <= cfgOutDivM1;
        oldMul <= cfgMultM1;
        oldBw  <= cfgBwM1;
        newIn  <= NR_W'(tgtInDiv - 1'b1);
        newOut <= NO_W'(tgtOutDiv - 1'b1);
        newMul <= NF_W'(tgtMult - 1'b1);
        newBw  <= NB_W'(tgtBw - 1'b1);
      end
      if (strb.modeWrOk) modeSel <= modeWrData;
      if (strb.park) begin
        parked <= (modeSel == MODE_PLL);
        if (modeSel == MODE_PLL) modeSel <= MODE_SLOW;
      end
      if (strb.restore) begin
        if (parked) modeSel <= MODE_PLL;
        parked <= 1'b0;
      end
      if (strb.setRst) pllRst <= 1'b1;
      else if (strb.clrRst) pllRst <= 1'b0;
      if (strb.clrErr) err <= 1'b0;
      else if (strb.setErr) err <= 1'b1;
      if (strb.writeCfg) begin
        cfgInDivM1  <= strb.useOld ? oldIn  : newIn;
        cfgOutDivM1 <= strb.useOld ? oldOut : newOut;
        cfgMultM1   <= strb.useOld ? oldMul : newMul;
        cfgBwM1     <= strb.useOld ? oldBw  : newBw;
      end
      if (strb.loadSettle) settleCnt <= settleLoad;
      else if (strb.decSettle) settleCnt <= settleCnt - 1'b1;
      if (strb.clrPoll) pollCnt <= '0;
      else if (strb.incPoll) pollCnt <= pollCnt + 1'b1;
    end
  end
endmodule

// File: rtl/pll_reprog_ctrl.sv
module pll_reprog_ctrl
  import pll_reprog_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     startReq,
  input  logic     modeWe,
  input  logic     lockIn,
  input  logic     settleZero,
  input  logic     pollLast,
  output seqStrb_t strb,
  output logic     busy
);
  seqState_t st, nxt;
  logic rollback, rbSet;

  assign busy = (st != ST_IDLE);

  always_comb begin
    strb  = '0;
    nxt   = st;
    rbSet = 1'b0;
    strb.useOld = rollback;
    case (st)
      ST_IDLE: begin
        if (startReq) begin
          strb.capture = 1'b1;
          strb.park    = 1'b1;
          strb.clrErr  = 1'b1;
          strb.setRst  = 1'b1;
          nxt          = ST_LOAD;
        end else begin
          strb.modeWrOk = modeWe;
        end
      end
      ST_LOAD: begin
        strb.writeCfg = 1'b1;
        nxt           = ST_RELEASE;
      end
      ST_RELEASE: begin
        strb.clrRst     = 1'b1;
        strb.loadSettle = 1'b1;
        nxt             = ST_SETTLE;
      end
      ST_SETTLE: begin
        if (settleZero) begin
          strb.clrPoll = 1'b1;
          nxt          = ST_POLL;
        end else begin
          strb.decSettle = 1'b1;
        end
      end
      ST_POLL: begin
        if (lockIn) begin
          nxt = ST_FINISH;
        end else if (pollLast) begin
          strb.setErr = 1'b1;
          if (!rollback) begin
            strb.setRst = 1'b1;
            rbSet       = 1'b1;
            nxt         = ST_LOAD;
          end else begin
            nxt = ST_FINISH;
          end
        end else begin
          strb.incPoll = 1'b1;
        end
      end
      ST_FINISH: begin
        strb.restore = 1'b1;
        strb.doneSet = 1'b1;
        nxt          = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st       <= ST_IDLE;
      rollback <= 1'b0;
    end else begin
      st <= nxt;
      if (strb.capture) rollback <= 1'b0;
      else if (rbSet) rollback <= 1'b1;
    end
  end
endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
  import pll_reprog_pkg::*;
#(
  parameter int NR_W     = 6,
  parameter int NO_W     = 4,
  parameter int NF_W     = 13,
  parameter int NB_W     = 12,
  parameter int US_CYC   = 24,
  parameter int POLL_MAX = 64
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            startReq,
  input  logic [NR_W:0]   tgtInDiv,
  input  logic [NO_W:0]   tgtOutDiv,
  input  logic [NF_W:0]   tgtMult,
  input  logic [NB_W:0]   tgtBw,
  input  logic            modeWe,
  input  logic [1:0]      modeWrData,
  input  logic            lockIn,
  output logic [1:0]      modeSel,
  output logic            pllRst,
  output logic [NR_W-1:0] cfgInDivM1,
  output logic [NO_W-1:0] cfgOutDivM1,
  output logic [NF_W-1:0] cfgMultM1,
  output logic [NB_W-1:0] cfgBwM1,
  output logic            busy,
  output logic            done,
  output logic            err
);
  seqStrb_t strb;
  logic settleZero, pollLast;

  pll_reprog_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .modeWe(modeWe),
    .lockIn(lockIn), .settleZero(settleZero), .pollLast(pollLast),
    .strb(strb), .busy(busy)
  );

  pll_reprog_dp #(
    .NR_W(NR_W), .NO_W(NO_W), .NF_W(NF_W), .NB_W(NB_W),
    .US_CYC(US_CYC), .POLL_MAX(POLL_MAX)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .tgtInDiv(tgtInDiv), .tgtOutDiv(tgtOutDiv), .tgtMult(tgtMult), .tgtBw(tgtBw),
    .modeWrData(modeWrData), .settleZero(settleZero), .pollLast(pollLast),
    .modeSel(modeSel), .pllRst(pllRst),
    .cfgInDivM1(cfgInDivM1), .cfgOutDivM1(cfgOutDivM1),
    .cfgMultM1(cfgMultM1), .cfgBwM1(cfgBwM1),
    .done(done), .err(err)
  );
endmodule

// File: rtl/pll_reprog_chk.sv
module pll_reprog_chk #(
  parameter int NR_W = 6,
  parameter int NO_W = 4,
  parameter int NF_W = 13,
  parameter int NB_W = 12
) (
  input logic            clk,
  input logic            rstN,
  input logic            startReq,
  input logic [1:0]      modeSel,
  input logic            pllRst,
  input logic [NR_W-1:0] cfgInDivM1,
  input logic [NO_W-1:0] cfgOutDivM1,
  input logic [NF_W-1:0] cfgMultM1,
  input logic [NB_W-1:0] cfgBwM1,
  input logic            busy,
  input logic            done,
  input logic            err
);
  p_park_mux_r2: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && !busy && modeSel == 2'd1) |=> (modeSel == 2'd0));

  p_fields_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!pllRst && !$past(pllRst)) |-> ($stable(cfgInDivM1) && $stable(cfgOutDivM1)
                                      && $stable(cfgMultM1) && $stable(cfgBwM1)));

  p_rst_in_op_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pllRst) |-> busy);

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_start_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && !busy) |=> !err);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  p_mode_frozen_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(modeSel));
endmodule

bind pll_reprog_seq pll_reprog_chk #(
  .NR_W(NR_W), .NO_W(NO_W), .NF_W(NF_W), .NB_W(NB_W)
) u_chk (
  .clk(clk), .rstN(rstN), .startReq(startReq), .modeSel(modeSel),
  .pllRst(pllRst), .cfgInDivM1(cfgInDivM1), .cfgOutDivM1(cfgOutDivM1),
  .cfgMultM1(cfgMultM1), .cfgBwM1(cfgBwM1), .busy(busy), .done(done), .err(err)
);

// File: tb/pll_reprog_seq_tb.sv
module pll_reprog_seq_tb;
  localparam int NR_W = 6, NO_W = 4, NF_W = 13, NB_W = 12;
  localparam int US = 2, PM = 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic startReq = 1'b0, modeWe = 1'b0, lockIn = 1'b0;
  logic [NR_W:0] tgtInDiv = '0;
  logic [NO_W:0] tgtOutDiv = '0;
  logic [NF_W:0] tgtMult = '0;
  logic [NB_W:0] tgtBw = '0;
  logic [1:0] modeWrData = '0;
  logic [1:0] modeSel;
  logic pllRst, busy, done, err;
  logic [NR_W-1:0] cfgInDivM1;
  logic [NO_W-1:0] cfgOutDivM1;
  logic [NF_W-1:0] cfgMultM1;
  logic [NB_W-1:0] cfgBwM1;

  always #2 clk = ~clk;

  pll_reprog_seq #(.NR_W(NR_W), .NO_W(NO_W), .NF_W(NF_W), .NB_W(NB_W),
                   .US_CYC(US), .POLL_MAX(PM)) u_dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .tgtInDiv(tgtInDiv),
    .tgtOutDiv(tgtOutDiv), .tgtMult(tgtMult), .tgtBw(tgtBw), .modeWe(modeWe),
    .modeWrData(modeWrData), .lockIn(lockIn), .modeSel(modeSel), .pllRst(pllRst),
    .cfgInDivM1(cfgInDivM1), .cfgOutDivM1(cfgOutDivM1), .cfgMultM1(cfgMultM1),
    .cfgBwM1(cfgBwM1), .busy(busy), .done(done), .err(err)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int settleCyc(int nrField);
    return (((nrField + 1) * 500) / 24 + 1) * US;
  endfunction

  // behavioural reference model
  int mSt, mCnt, mPoll, mMode;
  int mF[4], oF[4], tF[4];
  bit mPark, mRb, mErr, mRst, mDone;

  always @(posedge clk) begin
    if (!rstN) begin
      mSt = 0; mCnt = 0; mPoll = 0; mMode = 0;
      foreach (mF[i]) begin mF[i] = 0; oF[i] = 0; tF[i] = 0; end
      mPark = 0; mRb = 0; mErr = 0; mRst = 0; mDone = 0;
    end else begin
      mDone = 0;
      case (mSt)
        0: if (startReq) begin
             oF = mF;
             tF[0] = (int'(tgtInDiv) - 1) & ((1 << NR_W) - 1);
             tF[1] = (int'(tgtOutDiv) - 1) & ((1 << NO_W) - 1);
             tF[2] = (int'(tgtMult) - 1) & ((1 << NF_W) - 1);
             tF[3] = (int'(tgtBw) - 1) & ((1 << NB_W) - 1);
             mPark = (mMode == 1);
             if (mPark) mMode = 0;
             mErr = 0; mRst = 1; mRb = 0; mSt = 1;
           end else if (modeWe) mMode = int'(modeWrData);
        1: begin mF = mRb ? oF : tF; mSt = 2; end
        2: begin mRst = 0; mCnt = settleCyc(mF[0]) - 1; mSt = 3; end
        3: if (mCnt == 0) begin mSt = 4; mPoll = 0; end else mCnt--;
        4: if (lockIn) mSt = 5;
           else if (mPoll == PM - 1) begin
             mErr = 1;
             if (!mRb) begin mRb = 1; mRst = 1; mSt = 1; end else mSt = 5;
           end else mPoll++;
        default: begin
          if (mPark) mMode = 1;
          mPark = 0; mDone = 1; mSt = 0;
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      chk(int'(modeSel) == mMode, "R2 modeSel", modeSel, mMode);
      chk(pllRst == mRst, "R3 pllRst", pllRst, mRst);
      chk(int'(cfgInDivM1) == mF[0], "R3 cfgInDivM1", cfgInDivM1, mF[0]);
      chk(int'(cfgOutDivM1) == mF[1], "R3 cfgOutDivM1", cfgOutDivM1, mF[1]);
      chk(int'(cfgMultM1) == mF[2], "R3 cfgMultM1", cfgMultM1, mF[2]);
      chk(int'(cfgBwM1) == mF[3], "R3 cfgBwM1", cfgBwM1, mF[3]);
      chk(done == mDone, "R7 done", done, mDone);
      chk(err == mErr, "R6 err", err, mErr);
      chk(busy == (mSt != 0), "R8 busy", busy, mSt != 0);
    end
  end

  task automatic setMode(int m);
    @(negedge clk); modeWe = 1'b1; modeWrData = 2'(m);
    @(negedge clk); modeWe = 1'b0;
  endtask

  task automatic doStart(int a, int b, int c, int d);
    @(negedge clk);
    startReq = 1'b1;
    tgtInDiv = (NR_W+1)'(a); tgtOutDiv = (NO_W+1)'(b);
    tgtMult = (NF_W+1)'(c); tgtBw = (NB_W+1)'(d);
    @(negedge clk); startReq = 1'b0;
  endtask

  task automatic waitDone();
    while (!done) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    int n, s;
    int prev[4];
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state (R3, R7, R8)
    chk(pllRst == 0 && cfgInDivM1 == 0 && cfgMultM1 == 0, "R3 reset", pllRst, 0);
    chk(!done && !err && !busy, "R7 reset flags", {done, err, busy}, 0);

    // R10: parked mux returns after a clean lock
    setMode(1);
    lockIn = 1'b1;
    doStart(3, 2, 100, 50);
    chk(modeSel == 2'd0, "R2 parked", modeSel, 0);
    waitDone();
    chk(modeSel == 2'd1, "R10 restored", modeSel, 1);
    chk(cfgInDivM1 == 2 && cfgMultM1 == 99, "R3 minus one", cfgMultM1, 99);

    // R4: settle window timing, mode 0 untouched
    setMode(0);
    doStart(7, 1, 40, 20);
    while (pllRst) @(negedge clk);
    n = 0;
    while (!done) begin @(negedge clk); n++; end
    s = settleCyc(6);
    chk(n == s + 2, "R4 settle", n, s + 2);
    chk(modeSel == 2'd0, "R2 slow kept", modeSel, 0);

    // R5: lock arrives after several low samples
    lockIn = 1'b0;
    doStart(2, 3, 60, 30);
    while (pllRst) @(negedge clk);
    repeat (settleCyc(1) + 4) @(negedge clk);
    lockIn = 1'b1;
    waitDone();
    chk(!err && cfgInDivM1 == 1, "R5 late lock", err, 0);

    // R6 / R1: first pass times out, fallback locks
    prev[0] = cfgInDivM1; prev[1] = cfgOutDivM1; prev[2] = cfgMultM1; prev[3] = cfgBwM1;
    setMode(1);
    lockIn = 1'b0;
    doStart(9, 5, 200, 70);
    while (!err) @(negedge clk);
    lockIn = 1'b1;
    waitDone();
    chk(err == 1, "R6 err set", err, 1);
    chk(int'(cfgInDivM1) == prev[0] && int'(cfgMultM1) == prev[2], "R1 fallback fields",
        cfgMultM1, prev[2]);
    chk(int'(cfgBwM1) == prev[3], "R6 fallback bw", cfgBwM1, prev[3]);
    chk(modeSel == 2'd1, "R10 restored after rollback", modeSel, 1);

    // R9: both passes fail, deep mode untouched
    setMode(2);
    lockIn = 1'b0;
    doStart(4, 4, 300, 90);
    waitDone();
    chk(err == 1, "R9 err", err, 1);
    chk(int'(cfgMultM1) == prev[2], "R9 fallback kept", cfgMultM1, prev[2]);
    chk(modeSel == 2'd2, "R10 deep kept", modeSel, 2);
    @(negedge clk);
    chk(!busy, "R9 no third pass", busy, 0);

    // R7 / R8: start clears err; busy ignores start and mode writes
    lockIn = 1'b1;
    doStart(5, 2, 77, 33);
    chk(err == 0, "R7 err cleared", err, 0);
    @(negedge clk);
    startReq = 1'b1; tgtInDiv = 7'd20; tgtMult = 14'd500;
    modeWe = 1'b1; modeWrData = 2'd1;
    @(negedge clk);
    startReq = 1'b0; modeWe = 1'b0;
    waitDone();
    chk(cfgInDivM1 == 4 && cfgMultM1 == 76, "R8 busy start ignored", cfgMultM1, 76);
    chk(modeSel == 2'd2, "R8 busy mode write ignored", modeSel, 2);
    @(negedge clk);
    chk(!done, "R7 done one cycle", done, 0);
    repeat (2) @(negedge clk);
    finishRun();
  end
endmodule